// File: doc/BRIEF.md
# Bit-Serial Circulating Address Register with Incrementer

This block holds a 16-bit address in a register that rotates one bit per clock while an operation runs. Only one bit at a time passes a single write point, where a serial half adder and a one-bit carry flag change it. An operation shifts exactly 16 times, so every bit passes the write point once and the register ends up back in its resting alignment. Bits move least significant first.

Two kinds of serial operation exist. The first adds one or two to the address. The second inverts one selected bit, as a front panel does when a per-bit switch is touched. A clear request zeroes the register in a single cycle. A load strobe captures a 16-bit word in parallel. A serial request starts in two stages. The request cycle arms a flag. The following edge sets the run flag. Only the run flag lets the shift counter and the register advance. The parallel view of the register is valid whenever the block is not busy. While an operation runs, the view shows the rotated contents.

Top module: `addr_serial_inc`

## Requirements
- R1: After reset, addr_q is 0, shift_cnt is 0, and busy and done are both 0.
- R2: An increment or toggle request taken while idle raises busy in the next cycle. Shifting starts one cycle after that. shift_cnt then steps 0 to 15 on consecutive cycles and returns to 0. busy stays high for exactly 17 cycles.
- R3: When by_two is 0, an increment leaves addr_q equal to the old value plus 1, modulo 65536. The value 0xFFFF wraps to 0 and the carry out of bit 15 is discarded.
- R4: When by_two is 1, an increment leaves addr_q equal to the old value plus 2, modulo 65536. Bit 0 is unchanged.
- R5: A toggle request inverts bit tog_idx of addr_q and leaves every other bit unchanged. A bit that is 1 is cleared, and a bit that is 0 is set.
- R6: A clear request taken while idle makes addr_q 0 in the next cycle.
- R7: A load strobe taken while idle makes addr_q equal to load_data in the next cycle.
- R8: When requests arrive in the same cycle, clear wins over load, load wins over a serial start, and increment wins over toggle.
- R9: Clear, load, increment and toggle requests that arrive while busy is high have no effect on the register or on the operation in progress.
- R10: done is high for exactly one cycle. That cycle is the first one after the 16th shift, and busy is already low in it.
- R11: During an operation, after j shifts, addr_q holds the old bits j..15 in its low positions and the j lowest result bits in its top j positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_req | input | 1 | Clear the whole register |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 16 | Parallel load word |
| inc_req | input | 1 | Start a serial increment |
| by_two | input | 1 | Increment step select: 0 adds one, 1 adds two |
| tog_req | input | 1 | Start a serial single-bit inversion |
| tog_idx | input | 4 | Bit position to invert |
| addr_q | output | 16 | Parallel view of the register |
| shift_cnt | output | 4 | Current shift count |
| busy | output | 1 | Serial operation armed or running |
| done | output | 1 | One-cycle completion pulse |

## Verification
A behavioural model predicts the result of each operation as a whole word. It then derives the expected rotated view for every cycle of the run, which checks the LSB-first order and the write point at each count. Increments start from values that need different carry lengths:
- a zero low bit, where the carry stops at once;
- runs of ones that ripple the carry;
- 0xFFFF and 0xFFFE, which wrap.

Applied with both step sizes, these tell a correct skip of bit 0 apart from a carry injected too early or too late. Toggles on bits 0, 15 and middle positions, holding both 0 and 1, separate the set case from the clear case. Colliding requests, and requests made while busy, expose faults in priority and in the busy lockout.

// File: rtl/addr_inc_pkg.sv
package addr_inc_pkg;
  typedef enum logic {
    OP_INC = 1'b0,
    OP_TOG = 1'b1
  } op_e;
endpackage

// File: rtl/addr_inc_seq.sv
module addr_inc_seq
  import addr_inc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  op_e              start_op,
  input  logic             start_by2,
  input  logic [CNT_W-1:0] start_idx,
  output logic             arm,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output op_e              op_q,
  output logic             by2_q,
  output logic [CNT_W-1:0] idx_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm   <= 1'b0;
      run   <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
      op_q  <= OP_INC;
      by2_q <= 1'b0;
      idx_q <= '0;
    end else begin
      done <= 1'b0;
      if (!arm && !run) begin
        if (start) begin
          arm   <= 1'b1;
          op_q  <= start_op;
          by2_q <= start_by2;
          idx_q <= start_idx;
        end
      end else if (arm) begin
        arm <= 1'b0;
        run <= 1'b1;
        cnt <= '0;
      end else begin
        if (cnt == LAST) begin
          run  <= 1'b0;
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_run_follows_arm_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (run && cnt == '0));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != LAST) |=> (run && cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_finish_R10: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == LAST) |=> (!run && done));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_op_held_R9: assert property (@(posedge clk) disable iff (rst)
    (arm || run) |=> ($stable(op_q) && $stable(by2_q) && $stable(idx_q)));
endmodule

// File: rtl/addr_inc_alu.sv
module addr_inc_alu
  import addr_inc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  op_e              op,
  input  logic             by2,
  input  logic [CNT_W-1:0] idx,
  input  logic             bit_in,
  output logic             bit_out
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic carry_q;
  logic c_in;

  always_comb begin
    c_in = 1'b0;
    if (op == OP_INC) begin
      c_in = carry_q
           | ((cnt == '0) & ~by2)
           | ((cnt == CNT_W'(1)) & by2);
    end
    if (op == OP_INC) bit_out = bit_in ^ c_in;
    else              bit_out = bit_in ^ (cnt == idx);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || cnt == LAST) carry_q <= 1'b0;
    else                            carry_q <= c_in & bit_in;
  end

  assert_tog_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (run && op == OP_TOG) |=> !carry_q);
  assert_carry_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (run && op == OP_INC && !bit_in) |=> !carry_q);
endmodule

// File: rtl/addr_inc_shreg.sv
module addr_inc_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_d,
  input  logic         shift,
  input  logic         bit_wr,
  output logic         bit_rd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (load)   q <= load_d;
    else if (shift)  q <= {bit_wr, q[W-1:1]};
  end

  assign bit_rd = q[0];

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (q == $past(load_d)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !shift) |=> $stable(q));
endmodule

// File: rtl/addr_serial_inc.sv
module addr_serial_inc
  import addr_inc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_req,
  input  logic             load_en,
  input  logic [W-1:0]     load_data,
  input  logic             inc_req,
  input  logic             by_two,
  input  logic             tog_req,
  input  logic [CNT_W-1:0] tog_idx,
  output logic [W-1:0]     addr_q,
  output logic [CNT_W-1:0] shift_cnt,
  output logic             busy,
  output logic             done
);
  logic             arm, run;
  logic             idle;
  logic             clr_go, load_go, start_go;
  op_e              start_op, op_q;
  logic             by2_q;
  logic [CNT_W-1:0] idx_q;
  logic             bit_rd, bit_wr;

  assign idle     = !arm && !run;
  assign clr_go   = idle && clr_req;
  assign load_go  = idle && !clr_req && load_en;
  assign start_go = idle && !clr_req && !load_en && (inc_req || tog_req);
  assign start_op = inc_req ? OP_INC : OP_TOG;
  assign busy     = arm || run;

  addr_inc_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start_go), .start_op(start_op),
    .start_by2(by_two), .start_idx(tog_idx),
    .arm(arm), .run(run), .cnt(shift_cnt), .done(done),
    .op_q(op_q), .by2_q(by2_q), .idx_q(idx_q)
  );

  addr_inc_alu #(.W(W), .CNT_W(CNT_W)) u_alu (
    .clk(clk), .rst(rst), .run(run), .cnt(shift_cnt), .op(op_q),
    .by2(by2_q), .idx(idx_q), .bit_in(bit_rd), .bit_out(bit_wr)
  );

  addr_inc_shreg #(.W(W)) u_shreg (
    .clk(clk), .rst(rst), .clr(clr_go), .load(load_go), .load_d(load_data),
    .shift(run), .bit_wr(bit_wr), .bit_rd(bit_rd), .q(addr_q)
  );

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && (clr_req || load_en)) |=> busy || done);
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr_req && !load_en && (inc_req || tog_req)) |=> busy);
endmodule

// File: tb/addr_serial_inc_bench.sv
module addr_serial_inc_bench;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_req = 0, load_en = 0, inc_req = 0, by_two = 0, tog_req = 0;
  logic [15:0] load_data = '0;
  logic [3:0]  tog_idx = '0;
  logic [15:0] addr_q;
  logic [3:0]  shift_cnt;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  addr_serial_inc u_addr_serial_inc (
    .clk(clk), .rst(rst), .clr_req(clr_req), .load_en(load_en),
    .load_data(load_data), .inc_req(inc_req), .by_two(by_two),
    .tog_req(tog_req), .tog_idx(tog_idx), .addr_q(addr_q),
    .shift_cnt(shift_cnt), .busy(busy), .done(done)
  );

  // behavioural reference: phase 0 idle, 1 armed, 2..17 running
  int    phase = 0;
  int    m_old = 0, m_res = 0, m_reg = 0;
  bit    m_done = 0;
  string op_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; m_reg = 0; m_done = 0; op_tag = "R1";
    end else begin
      m_done = 0;
      if (phase == 0) begin
        if (clr_req) begin m_reg = 0; op_tag = "R6"; end
        else if (load_en) begin m_reg = int'(load_data); op_tag = "R7"; end
        else if (inc_req || tog_req) begin
          m_old = m_reg;
          if (inc_req) begin
            m_res = (m_reg + (by_two ? 2 : 1)) & 16'hFFFF;
            op_tag = by_two ? "R4" : "R3";
          end else begin
            m_res = m_reg ^ (1 << tog_idx);
            op_tag = "R5";
          end
          phase = 1;
        end
      end else if (phase == 17) begin
        phase = 0; m_reg = m_res; m_done = 1;
      end else phase++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int view();
    int j;
    if (phase < 2) return m_reg;
    j = phase - 2;
    if (j == 0) return m_old;
    return ((m_old >> j) | (m_res << (W - j))) & 16'hFFFF;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R2 busy", int'(busy), (phase != 0) ? 1 : 0);
      check("R2 shift_cnt", int'(shift_cnt), (phase >= 2) ? phase - 2 : 0);
      check("R10 done", int'(done), m_done ? 1 : 0);
      check((phase >= 3) ? "R11 view" : op_tag, int'(addr_q), view());
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulse(bit c, bit l, logic [15:0] d, bit i, bit b2, bit t, logic [3:0] x);
    @(negedge clk);
    clr_req = c; load_en = l; load_data = d; inc_req = i; by_two = b2;
    tog_req = t; tog_idx = x;
    @(negedge clk);
    clr_req = 0; load_en = 0; inc_req = 0; tog_req = 0;
  endtask

  task automatic wait_idle();
    repeat (18) @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] v);
    pulse(0, 1, v, 0, 0, 0, 0);
  endtask

  task automatic do_inc(logic [15:0] start, bit b2, logic [15:0] exp, string tag);
    do_load(start);
    pulse(0, 0, 0, 1, b2, 0, 0);
    wait_idle();
    check(tag, int'(addr_q), int'(exp));
  endtask

  task automatic do_tog(logic [15:0] start, logic [3:0] x, logic [15:0] exp);
    do_load(start);
    pulse(0, 0, 0, 0, 0, 1, x);
    wait_idle();
    check("R5 toggle", int'(addr_q), int'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 addr", int'(addr_q), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 cnt", int'(shift_cnt), 0);

    do_load(16'h1234);
    check("R7 load", int'(addr_q), 16'h1234);
    pulse(1, 0, 0, 0, 0, 0, 0);
    check("R6 clear", int'(addr_q), 0);

    do_inc(16'h0000, 0, 16'h0001, "R3 zero");
    do_inc(16'h00FF, 0, 16'h0100, "R3 ripple");
    do_inc(16'hFFFF, 0, 16'h0000, "R3 wrap");
    do_inc(16'hA5A4, 0, 16'hA5A5, "R3 short");
    do_inc(16'h0001, 1, 16'h0003, "R4 bit0 kept");
    do_inc(16'h00FE, 1, 16'h0100, "R4 ripple");
    do_inc(16'hFFFE, 1, 16'h0000, "R4 wrap");
    do_inc(16'hFFFF, 1, 16'h0001, "R4 wrap odd");
    do_tog(16'h0000, 4'd0, 16'h0001);
    do_tog(16'hFFFF, 4'd15, 16'h7FFF);
    do_tog(16'h8000, 4'd15, 16'h0000);
    do_tog(16'h0F0F, 4'd7, 16'h0F8F);

    // priority
    do_load(16'h5555);
    pulse(1, 1, 16'h1111, 1, 0, 0, 0);
    check("R8 clear over load", int'(addr_q), 0);
    pulse(0, 1, 16'h2222, 1, 0, 1, 4'd3);
    check("R8 load over start", int'(addr_q), 16'h2222);
    check("R8 no start", int'(busy), 0);
    pulse(0, 0, 0, 1, 0, 1, 4'd8);
    wait_idle();
    check("R8 inc over toggle", int'(addr_q), 16'h2223);

    // requests while busy
    do_load(16'h0010);
    pulse(0, 0, 0, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 1, 16'hBEEF, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 4'd0);
    pulse(0, 0, 0, 1, 1, 0, 0);
    repeat (10) @(negedge clk);
    check("R9 ignored while busy", int'(addr_q), 16'h0011);
    check("R9 idle after", int'(busy), 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule